// File: doc/BRIEF.md
# Multi-Mode ADC Sampling Sequencer

This block is the control engine that sits between an external two-channel ADC and the filter and cause logic of an always-on domain. It powers the converter up, waits a programmed settling time, walks the channel selects in a fixed order, and collects each converted word into a per-channel latest-value register. The filter comparisons happen outside the block. They return one match bit for each complete sample set.

Three operating modes are supported. In low-power scan the converter is woken once per programmed period, converts one set, and is powered down again. After a programmed number of consecutive matching sets, the sequencer escalates to normal scan. In normal scan, sets are converted back to back. After a second programmed run of consecutive matches, a single trigger pulse is raised for the wakeup or interrupt logic, and every channel's value is frozen into a triggered-value register. In oneshot mode exactly one set is converted. Completion is signalled whatever the data is, and the converter stays off until the enable is cycled or a soft reset is issued.

Top module: `adc_sequencer`

## Requirements
- R1: After reset the converter is powered down (`adc_pd_o`=1), no channel is selected, all pulses are low, and all latest and triggered values are zero.
- R2: When the sequencer starts a power-up, the converter is powered with no channel selected for exactly `pwrup_time_i`+1 cycles before the first select appears.
- R3: Within a set, channels are converted in ascending order 0 then 1. `adc_chsel_o` is one-hot, with bit i selecting channel i. A word accepted with `adc_valid_i` is stored in `latest_o[i*10 +: 10]` for the selected channel i.
- R4: The mode encoding is 0 = low-power scan, 1 = normal scan, 2 (or 3) = oneshot, latched when sampling starts. In low-power scan, each non-escalating set is followed by exactly `wake_time_i`+1 powered-down cycles before the next power-up.
- R5: In low-power scan, the set that completes `lp_thresh_i` consecutive matches produces a one-cycle `to_normal_o` pulse. The sequencer then converts continuously in normal scan with no further power-down. The normal-scan count starts with the next set.
- R6: `match_i` is sampled with the valid strobe of the last channel of a set. A set with `match_i`=0 clears the consecutive-match count in both scan modes. A threshold of 0 acts as 1.
- R7: In normal scan, the set that completes `np_thresh_i` consecutive matches produces a one-cycle `trigger_o` pulse and copies that set's values into `trig_val_o` (same layout as `latest_o`). `latest_o` keeps updating afterwards.
- R8: A run of matches triggers at most once. A further trigger needs a mismatching set followed by a new full run.
- R9: In oneshot mode, one set is converted, `oneshot_done_o` pulses regardless of `match_i`, and the converter stays powered down with no selects until the enable is cycled or a soft reset is issued.
- R10: With `enable_i` low, the converter is powered down and nothing is selected from the next cycle on. Setting it starts a power-up in the selected mode.
- R11: A `soft_rst_i` pulse clears the state machine and all match counts. If enabled, sampling restarts from power-up at once.
- R12: `to_normal_o`, `trigger_o` and `oneshot_done_o` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-on clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| enable_i | input | 1 | sequencer enable |
| soft_rst_i | input | 1 | one-cycle restart of state and counters |
| mode_i | input | 2 | operating mode (0 low-power, 1 normal, 2 oneshot) |
| pwrup_time_i | input | 8 | settling cycles after power-up |
| wake_time_i | input | 32 | low-power sleep period in cycles |
| lp_thresh_i | input | 8 | matches needed to leave low-power scan |
| np_thresh_i | input | 16 | consecutive matches needed to trigger |
| match_i | input | 1 | filter result for the set, taken with the last channel's strobe |
| adc_pd_o | output | 1 | converter power-down |
| adc_chsel_o | output | 2 | one-hot channel select |
| adc_data_i | input | 10 | converted word |
| adc_valid_i | input | 1 | converted word valid |
| latest_o | output | 20 | latest value per channel |
| trig_val_o | output | 20 | values of the triggering set |
| to_normal_o | output | 1 | escalation pulse |
| trigger_o | output | 1 | wakeup/interrupt request pulse |
| oneshot_done_o | output | 1 | oneshot completion pulse |

## Verification
The bench sweeps the settling time, the sleep period and both thresholds. It checks the escalation and trigger points against the exact set number where they must fall. A design whose timers are off by one shows up as a wrong count of powered or sleeping cycles. A counter that does not clear on a mismatch escalates or triggers one or more sets too early. A counter that does not saturate triggers again inside a single run of matches. The snapshot is compared with the bench's own record of the triggering set. A design that copies the previous set, or that keeps updating the triggered register, fails that comparison. Enable removal in mid-conversion and soft reset in both scan and oneshot modes are checked. A stale count would escalate early, and a dead oneshot path would never complete a second time.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [1:0] {
        MODE_LP      = 2'd0,
        MODE_NP      = 2'd1,
        MODE_ONESHOT = 2'd2
    } scan_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_CONV,
        ST_SLEEP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q >= limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i && !expired_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adcseq_match_ctr.sv
module adcseq_match_ctr #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic         match_i,
    input  logic [W-1:0] thr_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] thr_eff;
    logic         at_thr;

    // a zero threshold behaves like one
    assign thr_eff = (thr_i == '0) ? W'(1) : thr_i;
    assign at_thr  = (cnt_q == thr_eff);
    assign hit_o   = step_i && match_i && !at_thr && ((cnt_q + W'(1)) == thr_eff);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            if (!match_i)    cnt_d = '0;
            else if (!at_thr) cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adcseq_sample_regs.sv
module adcseq_sample_regs #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 10,
    parameter int IDX_W  = 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_i,
    input  logic [IDX_W-1:0]         ch_i,
    input  logic [DATA_W-1:0]        data_i,
    input  logic                     snap_i,
    output logic [NUM_CH*DATA_W-1:0] latest_o,
    output logic [NUM_CH*DATA_W-1:0] trig_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DATA_W-1:0] lat_d, lat_q, trg_d, trg_q;

        always_comb begin
            lat_d = lat_q;
            if (wr_i && (ch_i == IDX_W'(i))) lat_d = data_i;
            // the snapshot includes a word written in the same cycle
            trg_d = snap_i ? lat_d : trg_q;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                lat_q <= '0;
                trg_q <= '0;
            end else begin
                lat_q <= lat_d;
                trg_q <= trg_d;
            end
        end

        assign latest_o[i*DATA_W +: DATA_W] = lat_q;
        assign trig_o[i*DATA_W +: DATA_W]   = trg_q;
    end
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
    import adcseq_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int DATA_W   = 10,
    parameter int PWR_W    = 8,
    parameter int WAKE_W   = 32,
    parameter int LP_CNT_W = 8,
    parameter int NP_CNT_W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     enable_i,
    input  logic                     soft_rst_i,
    input  logic [1:0]               mode_i,
    input  logic [PWR_W-1:0]         pwrup_time_i,
    input  logic [WAKE_W-1:0]        wake_time_i,
    input  logic [LP_CNT_W-1:0]      lp_thresh_i,
    input  logic [NP_CNT_W-1:0]      np_thresh_i,
    input  logic                     match_i,
    output logic                     adc_pd_o,
    output logic [NUM_CH-1:0]        adc_chsel_o,
    input  logic [DATA_W-1:0]        adc_data_i,
    input  logic                     adc_valid_i,
    output logic [NUM_CH*DATA_W-1:0] latest_o,
    output logic [NUM_CH*DATA_W-1:0] trig_val_o,
    output logic                     to_normal_o,
    output logic                     trigger_o,
    output logic                     oneshot_done_o
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

    typedef struct packed {
        seq_state_e       st;
        scan_mode_e       mode;
        logic [IDX_W-1:0] ch;
        logic             to_norm;
        logic             trig;
        logic             done;
    } seq_t;

    seq_t d, q;

    logic              set_done, conv_wr, ctr_clr;
    logic              hit_lp, hit_np, tmr_exp;
    logic [WAKE_W-1:0] tmr_limit;
    scan_mode_e        mode_sel;

    assign conv_wr  = (q.st == ST_CONV) && adc_valid_i;
    assign set_done = conv_wr && (q.ch == LAST_CH);
    assign ctr_clr  = !enable_i || soft_rst_i || (q.st == ST_IDLE);

    assign tmr_limit = (q.st == ST_PWRUP) ? WAKE_W'(pwrup_time_i) : wake_time_i;

    always_comb begin
        case (mode_i)
            2'd0:    mode_sel = MODE_LP;
            2'd1:    mode_sel = MODE_NP;
            default: mode_sel = MODE_ONESHOT;
        endcase
    end

    always_comb begin
        d         = q;
        d.to_norm = 1'b0;
        d.trig    = 1'b0;
        d.done    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (enable_i) begin
                    d.st   = ST_PWRUP;
                    d.mode = mode_sel;
                end
            end
            ST_PWRUP: begin
                if (tmr_exp) begin
                    d.st = ST_CONV;
                    d.ch = '0;
                end
            end
            ST_CONV: begin
                if (adc_valid_i) begin
                    if (q.ch != LAST_CH) begin
                        d.ch = q.ch + IDX_W'(1);
                    end else begin
                        d.ch = '0;
                        case (q.mode)
                            MODE_LP: begin
                                if (hit_lp) begin
                                    d.to_norm = 1'b1;
                                    d.mode    = MODE_NP;
                                end else begin
                                    d.st = ST_SLEEP;
                                end
                            end
                            MODE_NP: d.trig = hit_np;
                            default: begin
                                d.done = 1'b1;
                                d.st   = ST_DONE;
                            end
                        endcase
                    end
                end
            end
            ST_SLEEP: begin
                if (tmr_exp) d.st = ST_PWRUP;
            end
            default: d.st = q.st;
        endcase
        if (soft_rst_i || !enable_i) begin
            d.st      = ST_IDLE;
            d.ch      = '0;
            d.to_norm = 1'b0;
            d.trig    = 1'b0;
            d.done    = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, mode: MODE_LP, ch: '0,
                   to_norm: 1'b0, trig: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    adcseq_timer #(.W(WAKE_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (d.st != q.st),
        .run_i     ((q.st == ST_PWRUP) || (q.st == ST_SLEEP)),
        .limit_i   (tmr_limit),
        .expired_o (tmr_exp)
    );

    adcseq_match_ctr #(.W(LP_CNT_W)) u_lp_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (ctr_clr),
        .step_i  (set_done && (q.mode == MODE_LP)),
        .match_i (match_i),
        .thr_i   (lp_thresh_i),
        .hit_o   (hit_lp)
    );

    adcseq_match_ctr #(.W(NP_CNT_W)) u_np_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (ctr_clr),
        .step_i  (set_done && (q.mode == MODE_NP)),
        .match_i (match_i),
        .thr_i   (np_thresh_i),
        .hit_o   (hit_np)
    );

    adcseq_sample_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (conv_wr),
        .ch_i     (q.ch),
        .data_i   (adc_data_i),
        .snap_i   (d.trig),
        .latest_o (latest_o),
        .trig_o   (trig_val_o)
    );

    assign adc_pd_o       = !((q.st == ST_PWRUP) || (q.st == ST_CONV));
    assign adc_chsel_o    = (q.st == ST_CONV) ? (NUM_CH'(1) << q.ch) : '0;
    assign to_normal_o    = q.to_norm;
    assign trigger_o      = q.trig;
    assign oneshot_done_o = q.done;
endmodule

// File: rtl/adc_sequencer_chk.sv
module adc_sequencer_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              enable_i,
    input logic              adc_pd_o,
    input logic [NUM_CH-1:0] adc_chsel_o,
    input logic              to_normal_o,
    input logic              trigger_o,
    input logic              oneshot_done_o
);
    // R3: at most one channel selected at any time
    p_onehot_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(adc_chsel_o));

    // R10: a powered-down converter never has a channel selected
    p_pd_nosel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_pd_o |-> (adc_chsel_o == '0));

    // R10: enable low powers the converter down by the next cycle
    p_disable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> adc_pd_o);

    // R12: single-cycle pulses
    p_norm_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        to_normal_o |=> !to_normal_o);
    p_trig_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trigger_o |=> !trigger_o);
    p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oneshot_done_o |=> !oneshot_done_o);

    // R9: oneshot completion coincides with power-down
    p_oneshot_pd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oneshot_done_o |-> adc_pd_o);

    // R5: escalation continues straight into conversion
    p_norm_awake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        to_normal_o |-> !adc_pd_o);
endmodule

bind adc_sequencer adc_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .enable_i       (enable_i),
    .adc_pd_o       (adc_pd_o),
    .adc_chsel_o    (adc_chsel_o),
    .to_normal_o    (to_normal_o),
    .trigger_o      (trigger_o),
    .oneshot_done_o (oneshot_done_o)
);

// File: tb/adc_sequencer_test.sv
module adc_sequencer_test;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        srst = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [7:0]  pwr = 8'd0;
    logic [31:0] wake = 32'd0;
    logic [7:0]  lpt = 8'd1;
    logic [15:0] npt = 16'd1;
    logic        match = 1'b0;
    logic        pd;
    logic [1:0]  sel;
    logic [9:0]  adata = '0;
    logic        avalid = 1'b0;
    logic [19:0] latest, trigv;
    logic        to_norm, trig, done;

    always #2.5 clk = ~clk;

    adc_sequencer uut (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .soft_rst_i(srst),
        .mode_i(mode), .pwrup_time_i(pwr), .wake_time_i(wake),
        .lp_thresh_i(lpt), .np_thresh_i(npt), .match_i(match),
        .adc_pd_o(pd), .adc_chsel_o(sel), .adc_data_i(adata),
        .adc_valid_i(avalid), .latest_o(latest), .trig_val_o(trigv),
        .to_normal_o(to_norm), .trigger_o(trig), .oneshot_done_o(done)
    );

    int vectors = 0, errors = 0, cycles = 0;

    // converter model and event monitor
    logic        model_clr = 1'b0;
    logic [63:0] mpat = '0;
    int sets_done, conv_num, wt_c, norm_cnt, norm_set, trig_cnt, done_cnt;
    int trig_set0, trig_set1, trig_bad, ord_bad, pd_hi_norm;
    int prun, last_pwr, srun, last_sleep;
    logic [1:0] prev_sel;
    logic [9:0] last_d0, last_d1;

    always @(negedge clk) begin
        if (model_clr) begin
            sets_done = 0; conv_num = 0; wt_c = 0; norm_cnt = 0; norm_set = -1;
            trig_cnt = 0; done_cnt = 0; trig_set0 = -1; trig_set1 = -1;
            trig_bad = 0; ord_bad = 0; pd_hi_norm = 0; prun = 0; last_pwr = -1;
            srun = 0; last_sleep = -1; prev_sel = 2'b00;
            last_d0 = '0; last_d1 = '0; avalid = 1'b0;
        end else begin
            if (to_norm) begin norm_cnt++; norm_set = sets_done; end
            if (trig) begin
                if (trig_cnt == 0) trig_set0 = sets_done;
                if (trig_cnt == 1) trig_set1 = sets_done;
                trig_cnt++;
                if (trigv != {last_d1, last_d0}) trig_bad++;
            end
            if (done) done_cnt++;
            if (norm_cnt > 0 && pd && en) pd_hi_norm++;
            if (!pd && sel == 2'b00) prun++;
            else if (sel != 2'b00 && prun > 0) begin last_pwr = prun; prun = 0; end
            else if (pd) prun = 0;
            if (pd && en) srun++;
            else if (!pd && srun > 0) begin last_sleep = srun; srun = 0; end
            // converter
            if (pd || sel == 2'b00) begin
                avalid = 1'b0; wt_c = 0;
                if (pd) prev_sel = 2'b00;
            end else if (wt_c == LAT) begin
                avalid = 1'b1; wt_c = 0; conv_num++;
                adata = 10'((conv_num * 37 + ((sel == 2'b10) ? 201 : 0) + 5) % 1024);
                if (sel == 2'b01) begin
                    if (prev_sel == 2'b01) ord_bad++;
                    last_d0 = adata;
                end else begin
                    if (prev_sel != 2'b01) ord_bad++;
                    last_d1 = adata;
                    match = mpat[sets_done % 64];
                    sets_done++;
                end
                prev_sel = sel;
            end else begin
                avalid = 1'b0; wt_c++;
            end
        end
    end

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_model();
        @(posedge clk); #1 model_clr = 1'b1;
        @(posedge clk); #1 model_clr = 1'b0;
    endtask

    task automatic wait_sets(input int n);
        int g = 0;
        while (sets_done < n && g < 20000) begin @(negedge clk); g++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] m);
        clr_model();
        @(posedge clk); #1 mode = m; en = 1'b1;
    endtask

    task automatic stop();
        @(posedge clk); #1 en = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic soft_pulse();
        @(posedge clk); #1 srst = 1'b1;
        @(posedge clk); #1 srst = 1'b0;
    endtask

    initial begin
        #10000000;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
    always @(posedge clk) cycles++;

    initial begin
        int s;
        model_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pd", pd == 1'b1, pd, 1);
        chk("R1 sel", sel == 2'b00, sel, 0);
        chk("R1 pulses", {to_norm, trig, done} == 3'b000, {to_norm, trig, done}, 0);
        chk("R1 values", latest == '0 && trigv == '0, latest, 0);
        model_clr = 1'b0;

        // R2, R3, R9: oneshot over several settling times
        foreach (pwr_list[i]) begin end
        for (int k = 0; k < 5; k++) begin
            pwr = 8'((k * k * 2 + k) % 20);
            mpat = '0;
            start(2'd2);
            wait_sets(1);
            chk("R2 settle", last_pwr == int'(pwr) + 1, last_pwr, int'(pwr) + 1);
            chk("R9 done unfiltered", done_cnt == 1, done_cnt, 1);
            chk("R3 order", ord_bad == 0, ord_bad, 0);
            chk("R3 latest", latest == {last_d1, last_d0}, latest, {last_d1, last_d0});
            repeat (20) @(negedge clk);
            chk("R9 no further sample", sets_done == 1 && pd, sets_done, 1);
            stop();
            chk("R10 idle pd", pd == 1'b1, pd, 1);
        end

        // R4, R5: low-power sweep of sleep period and threshold
        pwr = 8'd1; npt = 16'd1000; mpat = '1;
        for (int w = 0; w < 3; w++) begin
            for (int l = 1; l <= 3; l++) begin
                wake = 32'(w * 3); lpt = 8'(l);
                start(2'd0);
                wait_sets(l + 3);
                chk("R5 escalation set", norm_set == l && norm_cnt == 1, norm_set, l);
                chk("R5 stays awake", pd_hi_norm == 0, pd_hi_norm, 0);
                chk("R5 fresh count", trig_cnt == 0, trig_cnt, 0);
                if (l >= 2)
                    chk("R4 sleep period", last_sleep == w * 3 + 1, last_sleep, w * 3 + 1);
                stop();
            end
        end

        // R6: mismatch in low-power scan clears the count (M X M M)
        wake = 32'd2; lpt = 8'd2; mpat = 64'hFFFF_FFFF_FFFF_FFFD;
        start(2'd0);
        wait_sets(5);
        chk("R6 lp mismatch clears", norm_set == 4, norm_set, 4);
        stop();

        // R6: threshold zero acts as one
        lpt = 8'd0; mpat = '1;
        start(2'd0);
        wait_sets(2);
        chk("R6 zero threshold", norm_set == 1, norm_set, 1);
        stop();

        // R7, R8: normal scan trigger over several thresholds
        for (int n = 1; n <= 5; n += 2) begin
            npt = 16'(n); mpat = '1;
            start(2'd1);
            wait_sets(n + 4);
            chk("R7 trigger set", trig_set0 == n, trig_set0, n);
            chk("R7 snapshot", trig_bad == 0, trig_bad, 0);
            chk("R8 single trigger", trig_cnt == 1, trig_cnt, 1);
            chk("R7 latest moves on", latest != trigv && latest == {last_d1, last_d0}, latest, {last_d1, last_d0});
            chk("R3 order np", ord_bad == 0, ord_bad, 0);
            stop();
        end

        // R8, R6: rearm after a mismatch (1 1 0 1 1 1 ...)
        npt = 16'd2; mpat = 64'hFFFF_FFFF_FFFF_FFFB;
        start(2'd1);
        wait_sets(10);
        chk("R8 first trigger", trig_set0 == 2, trig_set0, 2);
        chk("R8 rearmed trigger", trig_set1 == 5, trig_set1, 5);
        chk("R8 trigger count", trig_cnt == 2, trig_cnt, 2);
        chk("R7 snapshots", trig_bad == 0, trig_bad, 0);

        // R10: enable removed mid-run
        @(posedge clk); #1 en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 powered down", pd == 1'b1 && sel == 2'b00, {pd, sel}, 4);
        s = sets_done;
        repeat (12) @(negedge clk);
        chk("R10 no conversion", sets_done == s, sets_done, s);

        // R11: soft reset in low-power scan restarts the match count
        pwr = 8'd1; wake = 32'd2; lpt = 8'd3; npt = 16'd1000; mpat = '1;
        start(2'd0);
        wait_sets(2);
        s = sets_done;
        soft_pulse();
        wait_sets(s + 4);
        chk("R11 count cleared", norm_set == s + 3 && norm_cnt == 1, norm_set, s + 3);
        stop();

        // R11, R9: soft reset re-arms oneshot
        mpat = '0;
        start(2'd2);
        wait_sets(1);
        repeat (5) @(negedge clk);
        soft_pulse();
        wait_sets(2);
        chk("R11 oneshot restart", done_cnt == 2 && sets_done == 2, done_cnt, 2);
        stop();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    int pwr_list[1] = '{0};
endmodule